// File: doc/BRIEF.md
# Audio Master Clock and Frame-Rate Generator

This block turns a single master clock into the timing strobes an audio core needs when it drives its own serial link. It produces a core-clock enable, which fires on every master clock cycle or on every second one. It produces a clock-output enable with its own independent halving choice. It also produces a bit clock and a left/right frame clock. The frame clock is a fixed integer division of the core clock, and the divisor is chosen by a mode bit and a four-bit rate code.

Everything runs in the master clock domain. The divided clocks are expressed as enables and registered levels, so no derived clock net is created. The frame counter, the bit clock and both frame-clock outputs restart together when the mode bit, the rate code or the core-halving bit changes. This means a retune never produces a runt half-frame.

Top module: `audio_rate_gen`

## Requirements
- R1: With `cfg_core_div2` low, `core_en` is high on every cycle. With it high, `core_en` alternates, high on every second cycle. All frame timing advances only on cycles where `core_en` is high.
- R2: `clkout_en` is high every cycle when `cfg_out_div2` is low and alternates when it is high, whatever the state of `cfg_core_div2`. Changing `cfg_out_div2` does not restart the frame timing.
- R3: In normal mode (`cfg_usb_mode`=0), rate code 4'b0000 gives a frame of 256 core ticks, so each frame-clock level lasts 128 ticks. Code 4'b0001 gives 384 core ticks, so each level lasts 192 ticks.
- R4: In 12 MHz mode (`cfg_usb_mode`=1), rate code 4'b0000 gives a frame of 250 core ticks, so each level lasts 125 ticks.
- R5: Any other rate code, in either mode, falls back to a 256-tick frame.
- R6: The bit clock is low during the first two core ticks of each 4-tick slot and high during the last two, with slots counted from the start of a half-frame. The last tick of a half-frame is always high. This gives 32, 48 and 31 rising bit-clock edges per half-frame for the 256, 384 and 250 divisors.
- R7: The frame clock changes level only in a cycle where the bit clock falls. `adc_lrc` and `dac_lrc` always carry the same level.
- R8: A change to `cfg_usb_mode`, `cfg_rate_code` or `cfg_core_div2` clears the frame counter, the bit clock and both frame clocks at the next master clock edge. The first frame-clock rise after the change comes a full half-frame later.
- R9: While `rst` is high, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_usb_mode | input | 1 | 0 = 256/384 x fs mode, 1 = 12 MHz mode |
| cfg_rate_code | input | 4 | Sample-rate code |
| cfg_core_div2 | input | 1 | Halve the master clock for the core tick |
| cfg_out_div2 | input | 1 | Halve the master clock for the clock output |
| core_en | output | 1 | Core clock enable |
| clkout_en | output | 1 | Clock-output enable |
| bclk | output | 1 | Bit clock level |
| adc_lrc | output | 1 | Record frame clock |
| dac_lrc | output | 1 | Playback frame clock |

## Verification
The in-line assertions check several properties on every cycle. They check the alternation of both enables and that the frame counter stays inside the selected half-frame. They check that the frame clock moves only on a bit-clock fall and that a retune clears the counter and clock levels one edge later. Only the bench scenarios can show the actual divisors. Those are the half-frame lengths in master cycles for each mode, rate code and halving choice, the rising-edge counts per half-frame, the fall-back for unknown codes, and that the first half-frame after a retune is full length.

// File: rtl/arg_pkg.sv
package arg_pkg;
  typedef struct packed {
    logic       usb_mode;
    logic [3:0] rate_code;
    logic       core_div2;
  } rate_cfg_t;

  localparam logic [3:0] CODE_BASE = 4'b0000;
  localparam logic [3:0] CODE_ALT  = 4'b0001;
endpackage

// File: rtl/arg_en_div2.sv
module arg_en_div2 (
  input  logic clk,
  input  logic rst,
  input  logic halve,
  output logic en_q
);
  logic tgl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tgl_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      tgl_q <= ~tgl_q;
      en_q  <= ~halve | tgl_q;
    end
  end

  // R1 R2
  en_alt_chk: assert property (@(posedge clk) disable iff (rst)
    (halve && $past(halve) && en_q) |=> !en_q);
  // R1 R2
  en_full_chk: assert property (@(posedge clk) disable iff (rst)
    !halve |=> en_q);
endmodule

// File: rtl/arg_rate_sel.sv
module arg_rate_sel #(
  parameter int DIV_BASE = 256,
  parameter int DIV_ALT  = 384,
  parameter int DIV_USB  = 250,
  parameter int HALF_W   = 8
) (
  input  logic              usb_mode,
  input  logic [3:0]        rate_code,
  output logic [HALF_W-1:0] half_len
);
  import arg_pkg::*;

  localparam logic [HALF_W-1:0] HALF_BASE = HALF_W'(DIV_BASE / 2);
  localparam logic [HALF_W-1:0] HALF_ALT  = HALF_W'(DIV_ALT / 2);
  localparam logic [HALF_W-1:0] HALF_USB  = HALF_W'(DIV_USB / 2);

  always_comb begin
    half_len = HALF_BASE;
    if (usb_mode) begin
      if (rate_code == CODE_BASE) half_len = HALF_USB;
    end else begin
      if (rate_code == CODE_ALT) half_len = HALF_ALT;
    end
  end
endmodule

// File: rtl/arg_frame_gen.sv
module arg_frame_gen #(
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              tick,
  input  logic [HALF_W-1:0] half_len,
  output logic              bclk_q,
  output logic              lrc_q
);
  logic [HALF_W-1:0] pos_q, pos_nx, last_pos;
  logic              at_last, bclk_nx;

  always_comb begin
    last_pos = half_len - HALF_W'(1);
    at_last  = (pos_q == last_pos);
    pos_nx   = at_last ? '0 : pos_q + HALF_W'(1);
    bclk_nx  = pos_nx[1] | (pos_nx == last_pos);
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      pos_q  <= '0;
      bclk_q <= 1'b0;
      lrc_q  <= 1'b0;
    end else if (tick) begin
      pos_q  <= pos_nx;
      bclk_q <= bclk_nx;
      if (at_last) lrc_q <= ~lrc_q;
    end
  end

  // R6
  pos_range_chk: assert property (@(posedge clk) disable iff (rst)
    !restart |-> (pos_q < half_len));
  // R6
  bclk_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !restart) |=> ($stable(bclk_q) && $stable(lrc_q)));
  // R7
  lrc_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(restart) && (lrc_q != $past(lrc_q))) |-> ($past(bclk_q) && !bclk_q));
  // R8
  restart_clear_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> (!lrc_q && !bclk_q && pos_q == '0));
endmodule

// File: rtl/audio_rate_gen.sv
module audio_rate_gen #(
  parameter int DIV_BASE = 256,
  parameter int DIV_ALT  = 384,
  parameter int DIV_USB  = 250
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_usb_mode,
  input  logic [3:0] cfg_rate_code,
  input  logic       cfg_core_div2,
  input  logic       cfg_out_div2,
  output logic       core_en,
  output logic       clkout_en,
  output logic       bclk,
  output logic       adc_lrc,
  output logic       dac_lrc
);
  import arg_pkg::*;

  localparam int MAX_AB  = (DIV_BASE > DIV_ALT) ? DIV_BASE : DIV_ALT;
  localparam int MAX_DIV = (MAX_AB > DIV_USB) ? MAX_AB : DIV_USB;
  localparam int HALF_W  = $clog2(MAX_DIV / 2 + 1);

  rate_cfg_t         cfg_now, cfg_q;
  logic              restart;
  logic [HALF_W-1:0] half_len;
  logic              lrc_q;

  assign cfg_now = '{usb_mode: cfg_usb_mode, rate_code: cfg_rate_code,
                     core_div2: cfg_core_div2};

  always_ff @(posedge clk) begin
    cfg_q <= cfg_now;
  end

  assign restart = !rst && (cfg_now != cfg_q);

  arg_en_div2 u_core_en (
    .clk  (clk),
    .rst  (rst),
    .halve(cfg_core_div2),
    .en_q (core_en)
  );

  arg_en_div2 u_out_en (
    .clk  (clk),
    .rst  (rst),
    .halve(cfg_out_div2),
    .en_q (clkout_en)
  );

  arg_rate_sel #(
    .DIV_BASE(DIV_BASE),
    .DIV_ALT (DIV_ALT),
    .DIV_USB (DIV_USB),
    .HALF_W  (HALF_W)
  ) u_rate (
    .usb_mode (cfg_usb_mode),
    .rate_code(cfg_rate_code),
    .half_len (half_len)
  );

  arg_frame_gen #(
    .HALF_W(HALF_W)
  ) u_frame (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .tick    (core_en),
    .half_len(half_len),
    .bclk_q  (bclk),
    .lrc_q   (lrc_q)
  );

  assign adc_lrc = lrc_q;
  assign dac_lrc = lrc_q;
endmodule

// File: tb/audio_rate_gen_bench.sv
module audio_rate_gen_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_usb_mode = 1'b0;
  logic [3:0] cfg_rate_code = 4'b0000;
  logic       cfg_core_div2 = 1'b0;
  logic       cfg_out_div2 = 1'b0;
  logic       core_en, clkout_en, bclk, adc_lrc, dac_lrc;

  int n_tests = 0;
  int n_fail  = 0;
  bit mon_on  = 1'b0;
  int q_len[$];
  int q_rise[$];

  always #4 clk = ~clk;

  audio_rate_gen u_audio_rate_gen (
    .clk(clk), .rst(rst),
    .cfg_usb_mode(cfg_usb_mode), .cfg_rate_code(cfg_rate_code),
    .cfg_core_div2(cfg_core_div2), .cfg_out_div2(cfg_out_div2),
    .core_en(core_en), .clkout_en(clkout_en), .bclk(bclk),
    .adc_lrc(adc_lrc), .dac_lrc(dac_lrc)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: pops expected half-frame length and bit-clock rise count
  initial begin
    bit have_ref = 1'b0;
    int since = 0;
    int rises = 0;
    logic lrc_p = 1'b0;
    logic bclk_p = 1'b0;
    forever begin
      @(negedge clk);
      if (!mon_on) begin
        have_ref = 1'b0;
      end else begin
        since++;
        if (bclk && !bclk_p) rises++;
        if (adc_lrc != lrc_p) begin
          if (have_ref && q_len.size() != 0) begin
            int el, er;
            el = q_len.pop_front();
            er = q_rise.pop_front();
            check(since == el, "R3/R4/R5 half-frame length", since, el);
            check(rises == er, "R6 bit-clock rises", rises, er);
            check(bclk_p && !bclk, "R7 frame clock on bit-clock fall", int'(bclk), 0);
          end
          have_ref = 1'b1;
          since = 0;
          rises = 0;
        end
        check(adc_lrc == dac_lrc, "R7 twin frame clocks", int'(dac_lrc), int'(adc_lrc));
      end
      lrc_p = adc_lrc;
      bclk_p = bclk;
    end
  end

  // Driver: retune, check restart and enables, then queue expected half-frames
  task automatic run_mode(input bit usb, input logic [3:0] code, input bit d2,
                          input bit od2, input int half_mclk, input int rise_n);
    int c = 0;
    bit ce_bad = 1'b0;
    bit co_bad = 1'b0;
    bit cleared = 1'b1;
    logic ce_p = 1'b0;
    logic co_p = 1'b0;
    mon_on = 1'b0;
    @(negedge clk);
    cfg_usb_mode = usb; cfg_rate_code = code;
    cfg_core_div2 = d2; cfg_out_div2 = od2;
    do begin
      @(negedge clk);
      c++;
      if (c == 2 && (adc_lrc || bclk)) cleared = 1'b0;
      if (c >= 4 && c <= 12) begin
        if (d2 ? (core_en == ce_p) : !core_en) ce_bad = 1'b1;
        if (od2 ? (clkout_en == co_p) : !clkout_en) co_bad = 1'b1;
      end
      ce_p = core_en;
      co_p = clkout_en;
    end while (!adc_lrc && c < half_mclk + 12);
    // R8 clear at next edge, then a full first half-frame
    check(cleared, "R8 clear after retune", int'(adc_lrc | bclk), 0);
    check(c >= half_mclk && c <= half_mclk + 3, "R8 first half-frame length", c, half_mclk);
    // R1 core enable pattern
    check(!ce_bad, "R1 core enable pattern", int'(ce_bad), 0);
    // R2 clock-output enable pattern
    check(!co_bad, "R2 clock-output enable pattern", int'(co_bad), 0);
    for (int i = 0; i < 3; i++) begin
      q_len.push_back(half_mclk);
      q_rise.push_back(rise_n);
    end
    mon_on = 1'b1;
    while (q_len.size() != 0) @(negedge clk);
    mon_on = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check(!core_en && !clkout_en && !bclk && !adc_lrc && !dac_lrc, "R9 reset outputs",
          int'({core_en, clkout_en, bclk, adc_lrc, dac_lrc}), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    run_mode(1'b0, 4'b0001, 1'b0, 1'b1, 192, 48);  // R3 alt divisor
    run_mode(1'b0, 4'b0000, 1'b0, 1'b0, 128, 32);  // R3 base divisor
    run_mode(1'b1, 4'b0000, 1'b0, 1'b0, 125, 31);  // R4
    run_mode(1'b1, 4'b0000, 1'b1, 1'b1, 250, 31);  // R4 with core halving
    run_mode(1'b0, 4'b0000, 1'b1, 1'b0, 256, 32);  // R1 R3
    run_mode(1'b0, 4'b1010, 1'b0, 1'b1, 128, 32);  // R5 normal fall-back
    run_mode(1'b1, 4'b0111, 1'b0, 1'b0, 128, 32);  // R5 12 MHz fall-back
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule